// File: doc/BRIEF.md
# Line Sensor Readout Timing Controller

This block runs on a fast system clock and produces every timing signal a 128-pixel integrating line sensor needs from its host. It divides the system clock down to a readout clock, places a start pulse around the first rising edge of each frame so that setup and hold are met, and ends the exposure early by raising a shutter line that stops the sensor from integrating. After each rising readout edge it waits for the sensor's analogue output to settle, then strobes an external converter and tags that strobe with the index of the pixel being presented. A one-cycle frame-done pulse follows the strobe of the last pixel.

The readout half-period and the exposure length come from configuration inputs and are captured at the start of every frame. A half-period that would push the readout clock above 5 MHz, or too short to fit the settling delay, is raised to the smallest legal value. In single-shot mode one start request produces one frame, and the readout clock then stops. In continuous mode the start pulse for the next frame follows clock 128 directly, so the sensor never falls into its free-running pixel-1 state. The setup/hold margin and the settling delay are compile-time parameters, and they are checked against their physical minimums at the system clock rate.

Top module: `lsc_ctrl`

## Requirements
- R1: While reset is held and on the cycle after it is released, sclk_o, si_o, shut_o, conv_o, frame_done_o and busy_o are all 0.
- R2: The effective half-period H is half_cfg_i, raised to MIN_HALF when smaller. MIN_HALF is 21 system cycles with the default parameters. sclk_o stays high for exactly H cycles, and its rising edges are exactly 2*H cycles apart within a run.
- R3: si_o goes high exactly SETUP_CYC cycles before the first sclk_o rising edge of a frame and goes low exactly HOLD_CYC cycles after that edge. It is low at every other time.
- R4: A single-shot frame has exactly 128 sclk_o rising edges, after which sclk_o stays low and busy_o returns to 0.
- R5: conv_o is a one-cycle pulse issued exactly SETTLE_CYC cycles after every sclk_o rising edge. pix_idx_o then carries the edge number minus one, so the first pixel is 0 and the last is 127.
- R6: frame_done_o is a one-cycle pulse on the cycle right after the conv_o pulse whose pix_idx_o is 127. It occurs once per frame.
- R7: shut_o rises exactly expo_cfg_i cycles after the falling edge of the third sclk_o pulse of a frame, counting in system cycles. With expo_cfg_i = 0 it never rises. It is cleared before the next start pulse and is never high while si_o is high.
- R8: With cont_i high, the next frame's start pulse rises SETUP_CYC cycles before sclk_o rising edge 129, and the readout clock period stays 2*H across the frame boundary.
- R9: A start_i pulse during a run has no effect. No extra si_o pulse is issued, and the frame still completes with 128 edges and 128 strobes.
- R10: A change of half_cfg_i in the middle of a frame does not alter that frame's readout period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| cont_i | input | 1 | Continuous-mode enable |
| half_cfg_i | input | HALF_W | Requested readout half-period in system cycles |
| expo_cfg_i | input | EXPO_W | Exposure length in system cycles, 0 = whole frame |
| sclk_o | output | 1 | Readout clock to the sensor |
| si_o | output | 1 | Start pulse to the sensor |
| shut_o | output | 1 | Shutter (integration suspend) to the sensor |
| conv_o | output | 1 | Converter strobe |
| pix_idx_o | output | IDX_W | Pixel index of the current strobe |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |
| busy_o | output | 1 | A frame is being read out |

## Verification
Single frames are run with a half-period below the legal minimum and with a legal one above it. This tells the clamp apart from plain pass-through, and it shows that edge, strobe and start-pulse offsets are counted from H rather than fixed. A non-zero exposure and a zero exposure separate the shutter timer from a shutter that is stuck or never armed. A two-frame continuous run shows whether the start pulse lands on edge 129 without a gap. A start request in mid-run and a mid-frame configuration change show whether the block ignores inputs that must not disturb a run in progress.

// File: rtl/lsc_pkg.sv
// Shared types and helpers for the line sensor timing controller.
package lsc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lsc_state_t;

    // Integer ceiling division for compile-time limits
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lsc_clkgen.sv
// Readout clock generator.
// Counts a phase from 0 to 2*H-1 while run_i is high. The readout clock is
// low for the first H phases and high for the last H, registered so it
// cannot glitch. Assumes half_i stays constant during a run apart from
// changes that land on a wrap cycle.
module lsc_clkgen #(
    parameter int HALF_W = 8,
    localparam int PH_W  = HALF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [HALF_W-1:0] half_i,
    output logic [PH_W-1:0]   ph_o,
    output logic              wrap_o,
    output logic              sclk_o
);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] period;
    logic            sclk_q;

    assign period = {half_i, 1'b0};
    assign wrap_o = run_i && (ph_q == period - PH_W'(1));
    assign ph_o   = ph_q;
    assign sclk_o = sclk_q;

    // Phase counter: runs while active, restarts each period
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) ph_q <= '0;
        else if (wrap_o)      ph_q <= '0;
        else                  ph_q <= ph_q + PH_W'(1);
    end

    // Registered readout clock decoded from the phase
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= run_i && (ph_q >= {1'b0, half_i});
    end

    p_ph_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (ph_q < period));

    p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !$past(run_i)) |-> !sclk_q);

endmodule

// File: rtl/lsc_shutter.sv
// Exposure timer and shutter output.
// The timer is loaded with the exposure length when sensor integration
// restarts, which is signalled by integ_i. When it runs out the shutter goes
// high. The shutter and the timer are cleared at each frame start, ahead of
// the start pulse. An exposure length of zero never closes the shutter.
module lsc_shutter #(
    parameter int EXPO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              integ_i,
    input  logic [EXPO_W-1:0] expo_i,
    output logic              shut_o
);

    logic [EXPO_W-1:0] cnt_q;
    logic              shut_q;

    assign shut_o = shut_q;

    // Count down the exposure and close the shutter when it expires
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start_i) begin
            cnt_q  <= '0;
            shut_q <= 1'b0;
        end else if (integ_i) begin
            cnt_q  <= expo_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - EXPO_W'(1);
            if (cnt_q == EXPO_W'(1)) shut_q <= 1'b1;
        end
    end

    p_shut_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> !shut_q);

endmodule

// File: rtl/lsc_seq.sv
// Frame sequencer.
// Tracks idle/run state and the readout period within a frame, and captures
// the configuration at each frame start. It decodes the start pulse,
// converter strobe, pixel index, frame-done and exposure events from the
// period and the phase. Every output is registered one cycle behind the phase
// decode, the same delay the clock generator applies to the readout clock,
// so all offsets are exact in system cycles.
module lsc_seq
    import lsc_pkg::*;
#(
    parameter int NPIX       = 128,
    parameter int HALF_W     = 8,
    parameter int EXPO_W     = 16,
    parameter int SETUP_CYC  = 5,
    parameter int HOLD_CYC   = 5,
    parameter int SETTLE_CYC = 20,
    parameter int MIN_HALF   = 21,
    localparam int IDX_W     = $clog2(NPIX),
    localparam int PH_W      = HALF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic [HALF_W-1:0] half_cfg_i,
    input  logic [EXPO_W-1:0] expo_cfg_i,
    input  logic [PH_W-1:0]   ph_i,
    input  logic              wrap_i,
    output logic              run_o,
    output logic [HALF_W-1:0] half_o,
    output logic [EXPO_W-1:0] expo_o,
    output logic              frame_start_o,
    output logic              integ_o,
    output logic              si_o,
    output logic              conv_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              done_o
);

    localparam int INTEG_PER = 3;  // integration restarts when clock 3 falls
    localparam logic [IDX_W-1:0] LAST_PER = IDX_W'(NPIX - 1);

    lsc_state_t        state_q;
    logic [IDX_W-1:0]  per_q;
    logic [HALF_W-1:0] half_q;
    logic [EXPO_W-1:0] expo_q;
    logic [HALF_W-1:0] half_eff;
    logic [PH_W-1:0]   half_ph;
    logic              run;
    logic              si_d, conv_d;
    logic              si_q, conv_q, done_q;
    logic [IDX_W-1:0]  idx_q;

    assign run      = (state_q == ST_RUN);
    assign half_eff = (half_cfg_i < HALF_W'(MIN_HALF)) ? HALF_W'(MIN_HALF) : half_cfg_i;
    assign half_ph  = {1'b0, half_q};

    // Event decodes from the current period and phase
    always_comb begin
        si_d          = run && (per_q == '0)
                        && (ph_i >= half_ph - PH_W'(SETUP_CYC))
                        && (ph_i <  half_ph + PH_W'(HOLD_CYC));
        conv_d        = run && (ph_i == half_ph + PH_W'(SETTLE_CYC));
        frame_start_o = run && (per_q == '0) && (ph_i == '0);
        integ_o       = run && (per_q == IDX_W'(INTEG_PER)) && (ph_i == '0);
    end

    // Frame state, period count and configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            per_q   <= '0;
            half_q  <= HALF_W'(MIN_HALF);
            expo_q  <= '0;
        end else if (!run) begin
            per_q <= '0;
            if (start_i || cont_i) begin
                state_q <= ST_RUN;
                half_q  <= half_eff;
                expo_q  <= expo_cfg_i;
            end
        end else if (wrap_i) begin
            if (per_q == LAST_PER) begin
                per_q <= '0;
                if (cont_i) begin
                    half_q <= half_eff;
                    expo_q <= expo_cfg_i;
                end else begin
                    state_q <= ST_IDLE;
                end
            end else begin
                per_q <= per_q + IDX_W'(1);
            end
        end
    end

    // Registered sensor start pulse, converter strobe, index and frame-done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_q   <= 1'b0;
            conv_q <= 1'b0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            si_q   <= si_d;
            conv_q <= conv_d;
            if (conv_d) idx_q <= per_q;
            done_q <= conv_q && (idx_q == LAST_PER);
        end
    end

    assign run_o  = run;
    assign half_o = half_q;
    assign expo_o = expo_q;
    assign si_o   = si_q;
    assign conv_o = conv_q;
    assign idx_o  = idx_q;
    assign done_o = done_q;

    p_conv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_q |=> !conv_q);

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(conv_q) && ($past(idx_q) == LAST_PER)));

    p_half_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (half_q >= HALF_W'(MIN_HALF)));

endmodule

// File: rtl/lsc_ctrl.sv
// Line sensor readout timing controller, top level.
// Connects the sequencer, the readout clock generator and the exposure
// shutter, and checks the timing parameters against their physical minimums
// (50 ns setup/hold, 200 ns settling, 5 MHz readout clock) at SYS_MHZ.
// Assumes the converter samples on conv_o and uses pix_idx_o in that cycle.
module lsc_ctrl
    import lsc_pkg::*;
#(
    parameter int SYS_MHZ    = 100,
    parameter int NPIX       = 128,
    parameter int HALF_W     = 8,
    parameter int EXPO_W     = 16,
    parameter int SETUP_CYC  = 5,
    parameter int HOLD_CYC   = 5,
    parameter int SETTLE_CYC = 20,
    localparam int IDX_W     = $clog2(NPIX),
    localparam int PH_W      = HALF_W + 1,
    localparam int MIN_EDGE  = ceil_div(SYS_MHZ * 50, 1000),
    localparam int MIN_SETL  = ceil_div(SYS_MHZ * 200, 1000),
    localparam int MIN_RATE  = ceil_div(SYS_MHZ, 10),
    localparam int MIN_HALF  = imax(imax(MIN_RATE, SETUP_CYC),
                                    imax(HOLD_CYC + 1, SETTLE_CYC + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic [HALF_W-1:0] half_cfg_i,
    input  logic [EXPO_W-1:0] expo_cfg_i,
    output logic              sclk_o,
    output logic              si_o,
    output logic              shut_o,
    output logic              conv_o,
    output logic [IDX_W-1:0]  pix_idx_o,
    output logic              frame_done_o,
    output logic              busy_o
);

    if (SETUP_CYC < MIN_EDGE || HOLD_CYC < MIN_EDGE) begin : g_bad_margin
        $error("setup/hold margin below 50 ns");
    end
    if (SETTLE_CYC < MIN_SETL) begin : g_bad_settle
        $error("settling delay below 200 ns");
    end
    if (MIN_HALF >= (1 << HALF_W)) begin : g_bad_width
        $error("HALF_W too narrow for the minimum half-period");
    end
    if (NPIX < 4) begin : g_bad_npix
        $error("NPIX must cover the integration restart period");
    end

    logic              run;
    logic [HALF_W-1:0] half;
    logic [EXPO_W-1:0] expo;
    logic [PH_W-1:0]   ph;
    logic              wrap;
    logic              frame_start, integ;

    lsc_seq #(
        .NPIX(NPIX), .HALF_W(HALF_W), .EXPO_W(EXPO_W),
        .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
        .SETTLE_CYC(SETTLE_CYC), .MIN_HALF(MIN_HALF)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .half_cfg_i(half_cfg_i), .expo_cfg_i(expo_cfg_i),
        .ph_i(ph), .wrap_i(wrap), .run_o(run), .half_o(half), .expo_o(expo),
        .frame_start_o(frame_start), .integ_o(integ), .si_o(si_o),
        .conv_o(conv_o), .idx_o(pix_idx_o), .done_o(frame_done_o)
    );

    lsc_clkgen #(.HALF_W(HALF_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run_i(run), .half_i(half),
        .ph_o(ph), .wrap_o(wrap), .sclk_o(sclk_o)
    );

    lsc_shutter #(.EXPO_W(EXPO_W)) u_shutter (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .integ_i(integ), .expo_i(expo), .shut_o(shut_o)
    );

    assign busy_o = run;

    p_si_rise_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_o) |-> !sclk_o);

    p_si_fall_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(si_o) |-> sclk_o);

    p_shut_off_during_si_r7: assert property (@(posedge clk) disable iff (!rst_n)
        si_o |-> !shut_o);

    p_strobe_in_high_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> sclk_o);

endmodule

// File: tb/lsc_ctrl_tb.sv
// Directed bench for lsc_ctrl. A negedge monitor records event times; each
// scenario task configures, runs and checks its own results.
module lsc_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SETUP  = 5;
    localparam int HOLD   = 5;
    localparam int SETTLE = 20;
    localparam int MINH   = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cont_i = 1'b0;
    logic [7:0]  half_cfg_i = 8'd21;
    logic [15:0] expo_cfg_i = 16'd0;
    logic        sclk_o, si_o, shut_o, conv_o, frame_done_o, busy_o;
    logic [6:0]  pix_idx_o;

    lsc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .half_cfg_i(half_cfg_i), .expo_cfg_i(expo_cfg_i),
        .sclk_o(sclk_o), .si_o(si_o), .shut_o(shut_o), .conv_o(conv_o),
        .pix_idx_o(pix_idx_o), .frame_done_o(frame_done_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;

    // monitor state
    int cyc = 0, exp_half = MINH;
    int n_rise, n_fall, t_last_rise, t_fall3, t_r129, per_bad, high_bad;
    int n_conv, conv_bad, n_done, done_bad, n_si, shut_bad, n_shut, t_shut;
    int t_first_rise;
    int si_rise_t[4], si_rise_n[4], si_fall_t[4];
    logic p_sclk = 0, p_si = 0, p_shut = 0, p_conv = 0;
    logic [6:0] p_idx = 0;

    task automatic mon_clear();
        n_rise = 0; n_fall = 0; t_last_rise = 0; t_fall3 = -1; t_r129 = -1;
        per_bad = 0; high_bad = 0; n_conv = 0; conv_bad = 0; n_done = 0;
        done_bad = 0; n_si = 0; shut_bad = 0; n_shut = 0; t_shut = -1;
        t_first_rise = -1;
        for (int i = 0; i < 4; i++) begin
            si_rise_t[i] = -1; si_rise_n[i] = -1; si_fall_t[i] = -1;
        end
    endtask

    // Record output events away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk_o && !p_sclk) begin
            if (n_rise > 0 && cyc - t_last_rise != 2*exp_half) per_bad++;
            if (n_rise == 0) t_first_rise = cyc;
            n_rise++;
            if (n_rise == 129) t_r129 = cyc;
            t_last_rise = cyc;
        end
        if (!sclk_o && p_sclk) begin
            if (cyc - t_last_rise != exp_half) high_bad++;
            n_fall++;
            if (n_fall == 3) t_fall3 = cyc;
        end
        if (conv_o) begin
            n_conv++;
            if (p_conv || int'(pix_idx_o) != n_rise - 1 || cyc - t_last_rise != SETTLE)
                conv_bad++;
        end
        if (frame_done_o) begin
            n_done++;
            if (!(p_conv && p_idx == 7'd127)) done_bad++;
        end
        if (si_o && !p_si) begin
            if (n_si < 4) begin si_rise_t[n_si] = cyc; si_rise_n[n_si] = n_rise; end
        end
        if (!si_o && p_si) begin
            if (n_si < 4) si_fall_t[n_si] = cyc;
            n_si++;
        end
        if (si_o && shut_o) shut_bad++;
        if (shut_o && !p_shut) begin n_shut++; t_shut = cyc; end
        p_sclk = sclk_o; p_si = si_o; p_shut = shut_o; p_conv = conv_o; p_idx = pix_idx_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_frames(input int k);
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (n_done >= k && !busy_o) break;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic wait_rises(input int k);
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (n_rise >= k) break;
        end
    endtask

    // R1: outputs idle in and just after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 outputs in reset", {sclk_o, si_o, shut_o, conv_o, frame_done_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after release", {sclk_o, si_o, shut_o, conv_o, frame_done_o, busy_o}, 0);
    endtask

    // R2-R7: one single-shot frame
    task automatic t_single(input int half, input int expo, input int eh);
        mon_clear(); exp_half = eh;
        half_cfg_i = 8'(half); expo_cfg_i = 16'(expo); cont_i = 1'b0;
        pulse_start();
        wait_frames(1);
        chk("R2 period errors", per_bad, 0);
        chk("R2 high-time errors", high_bad, 0);
        chk("R4 rising edges", n_rise, 128);
        chk("R4 idle after frame", {sclk_o, busy_o}, 0);
        chk("R3 si pulses", n_si, 1);
        chk("R3 si setup", t_first_rise - si_rise_t[0], SETUP);
        chk("R3 si hold", si_fall_t[0] - t_first_rise, HOLD);
        chk("R5 strobes", n_conv, 128);
        chk("R5 strobe errors", conv_bad, 0);
        chk("R6 done pulses", n_done, 1);
        chk("R6 done errors", done_bad, 0);
        chk("R7 shutter during si", shut_bad, 0);
        if (expo == 0) chk("R7 no shutter", n_shut, 0);
        else chk("R7 shutter time", t_shut - t_fall3, expo);
    endtask

    // R8: two back-to-back continuous frames
    task automatic t_cont();
        mon_clear(); exp_half = MINH;
        half_cfg_i = 8'(MINH); expo_cfg_i = 16'd300;
        @(negedge clk) cont_i = 1'b1;
        wait_rises(130);
        @(negedge clk) cont_i = 1'b0;
        wait_frames(2);
        chk("R8 rising edges", n_rise, 256);
        chk("R8 si pulses", n_si, 2);
        chk("R8 edges before second si", si_rise_n[1], 128);
        chk("R8 second si setup", t_r129 - si_rise_t[1], SETUP);
        chk("R8 period errors", per_bad, 0);
        chk("R8 done pulses", n_done, 2);
        chk("R7 shutter rises per frame", n_shut, 2);
        chk("R7 shutter during si", shut_bad, 0);
    endtask

    // R9: start request in the middle of a run
    task automatic t_ignore_start();
        mon_clear(); exp_half = MINH;
        half_cfg_i = 8'(MINH); expo_cfg_i = 16'd0;
        pulse_start();
        wait_rises(50);
        pulse_start();
        wait_frames(1);
        chk("R9 si pulses", n_si, 1);
        chk("R9 rising edges", n_rise, 128);
        chk("R9 strobes", n_conv, 128);
        chk("R9 strobe errors", conv_bad, 0);
    endtask

    // R10: configuration change mid-frame
    task automatic t_cfg_latch();
        mon_clear(); exp_half = 25;
        half_cfg_i = 8'd25; expo_cfg_i = 16'd0;
        pulse_start();
        wait_rises(10);
        @(negedge clk) half_cfg_i = 8'd40;
        wait_frames(1);
        chk("R10 period errors", per_bad, 0);
        chk("R10 high-time errors", high_bad, 0);
        chk("R10 rising edges", n_rise, 128);
    endtask

    initial begin
        mon_clear();
        t_reset();
        t_single(3, 700, MINH);   // clamped half-period, shutter mid-frame
        t_single(30, 0, 30);      // legal half-period, shutter disabled
        t_cont();
        t_ignore_start();
        t_cfg_latch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule